// File: doc/BRIEF.md
# VFD Grid Scan and Dimming Sequencer

This block turns a small display memory into the time-multiplexed drive pattern for a vacuum fluorescent display. It scans 7 to 10 grids, one at a time, and gives each grid a slot of 16 equal sub-steps. Within a slot, the enables for the grid and its segments are on only for the last 5, 6, 14 or 15 sub-steps, as a duty code selects. The leading dark sub-steps give four brightness levels and a blanking gap between digits. A prescaler sets how many clocks each sub-step lasts.

There are 26 physical lines. Eight are dedicated segment lines. Ten lines can carry either a grid or a high segment. Eight lines can carry either a grid or a general-purpose port bit. A start code places the grid block on the physical lines. Lines outside the grid block fall back to their segment or port role. Segment data comes from memory, which the block reads continuously through a synchronous read port. Each grid's 18 segment bits are captured into a working register at the start of that grid's slot, so a memory write never changes a slot that is already on screen.

Top module: `vfd_scan`

## Requirements
- R1: While `rst_n` is low, `shared_on` and `seg_on` are all zero. After reset is released, the scan restarts at grid 0, sub-step 0.
- R2: One sub-step lasts `prescale`+1 clocks. A slot is 16 sub-steps long.
- R3: Inside a slot, the display enables are off for the first sub-steps and on for the last W sub-steps. W is set by `duty`: 0 gives 5, 1 gives 6, 2 gives 14, 3 gives 15.
- R4: Grids are scanned 0,1,…,N-1 and then wrap to 0. N is `grid_cnt`, with values below 7 treated as 7 and values above 10 treated as 10.
- R5: The grid block sits on `shared_on` lines. Start code c places its top line at 17-c; codes above 10 act as 10. Grid i drives line 17-c-(N-1)+i. A grid whose line index is below 0 drives no line. No other line in the block is driven while a grid is active.
- R6: `seg_on[s]` carries segment s for s = 0..7. A shared line k in 8..17 that lies outside the grid block carries segment 25-k, but only if 25-k is below the segment count. The segment count is `seg_cnt` clamped to the range 8..18.
- R7: Grid i's data sits at addresses 0x09+4i, +1 and +2. At 0x09+4i, bits 1:0 are segments 17:16 and the other bits are ignored. At +1, bit b is segment 8+b. At +2, bit b is segment b. Read data is expected one clock after `mem_addr`.
- R8: Shared lines 0..7 outside the grid block show `port_val[k]`. Display on/off and duty do not affect them. A grid in the block takes priority over the port bit on that line.
- R9: With `disp_on` low, every grid and segment enable is zero.
- R10: A slot shows the memory contents as they were at its start. Writes during a slot first appear in that grid's next slot. The first slot after reset is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale | input | PRE_W | Clocks per sub-step, minus one |
| grid_cnt | input | 4 | Number of grids to scan |
| grid_start | input | 4 | Start code for the grid block |
| seg_cnt | input | 5 | Number of segments in use |
| duty | input | 2 | On-width code |
| disp_on | input | 1 | Display enable |
| port_val | input | 8 | Port bits for lines 0..7 |
| mem_addr | output | ADDR_W | Display memory read address |
| mem_rdata | input | 8 | Display memory read data, one clock late |
| shared_on | output | 18 | Grid, segment or port enables for lines 0..17 |
| seg_on | output | 8 | Enables for the dedicated segment lines 0..7 |

## Verification
Assertions watch these properties on every cycle:
- Outputs stay quiet in reset and while the display is off.
- Nothing lights during the leading dark sub-steps.
- The sub-step counter only steps by one.
- The read address stays inside the grid data layout.
- The segment outputs hold still within a sub-step, which is the no-tearing property.

Some behaviour only the bench's sweeps over grid count, start code, duty, segment count and prescale can show:
- where each grid lands on the physical lines;
- how shared lines divide between grid, segment and port roles;
- the wrap order;
- that a mid-slot memory write stays hidden until that grid's next slot.

// File: rtl/vfd_scan.sv
module vfd_scan #(
  parameter int PRE_W = 8,
  parameter int ADDR_W = 6,
  parameter int BASE = 9,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [3:0]        grid_cnt,
  input  logic [3:0]        grid_start,
  input  logic [4:0]        seg_cnt,
  input  logic [1:0]        duty,
  input  logic              disp_on,
  input  logic [7:0]        port_val,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [17:0]       shared_on,
  output logic [7:0]        seg_on
);
  localparam int NSEG = 18;

  logic [PRE_W-1:0] pre_q;
  logic [3:0]       sub_q, grid_q, n_eff, last, nxt_idx, st_code, thr;
  logic [1:0]       ph_q, ph_d;
  logic [NSEG-1:0]  nxt_q, cur_q;
  logic             tick, slot_end, lit;
  int               top_i, lo_i, act_i, segs_i;

  assign tick     = pre_q == prescale;
  assign slot_end = tick && sub_q == 4'd15;
  assign n_eff    = (grid_cnt < 4'd7) ? 4'd7 : (grid_cnt > 4'd10) ? 4'd10 : grid_cnt;
  assign last     = n_eff - 4'd1;
  assign nxt_idx  = (grid_q >= last) ? 4'd0 : grid_q + 4'd1;
  assign st_code  = (grid_start > 4'd10) ? 4'd10 : grid_start;
  assign mem_addr = ADDR_W'(BASE) + ADDR_W'(nxt_idx) * ADDR_W'(STRIDE) + ADDR_W'(ph_q);

  always_comb begin
    case (duty)
      2'd0: thr = 4'd11;
      2'd1: thr = 4'd10;
      2'd2: thr = 4'd2;
      default: thr = 4'd1;
    endcase
  end

  assign lit    = rst_n && disp_on && (sub_q >= thr);
  assign top_i  = 17 - int'(st_code);
  assign lo_i   = top_i - int'(n_eff) + 1;
  assign act_i  = lo_i + int'(grid_q);
  assign segs_i = (seg_cnt < 5'd8) ? 8 : (seg_cnt > 5'd18) ? 18 : int'(seg_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sub_q  <= '0;
      grid_q <= '0;
      ph_q   <= '0;
      ph_d   <= '0;
      nxt_q  <= '0;
      cur_q  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) sub_q <= sub_q + 4'd1;
      if (slot_end) begin
        grid_q <= nxt_idx;
        cur_q  <= nxt_q;
      end
      ph_q <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
      ph_d <= ph_q;
      case (ph_d)
        2'd0: nxt_q[17:16] <= mem_rdata[1:0];
        2'd1: nxt_q[15:8]  <= mem_rdata;
        default: nxt_q[7:0] <= mem_rdata;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      if (k >= lo_i && k <= top_i) shared_on[k] = lit && (k == act_i);
      else                         shared_on[k] = rst_n && port_val[k];
    end
    for (int k = 8; k < 18; k++) begin
      if (k >= lo_i && k <= top_i) shared_on[k] = lit && (k == act_i);
      else                         shared_on[k] = lit && ((25 - k) < segs_i) && cur_q[25 - k];
    end
  end

  assign seg_on = lit ? cur_q[7:0] : 8'd0;
endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_on,
  input logic [1:0]        duty,
  input logic [17:0]       shared_on,
  input logic [7:0]        seg_on,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        sub_q,
  input logic [3:0]        grid_q
);
  logic [3:0] dark_steps;
  always_comb begin
    case (duty)
      2'd0: dark_steps = 4'd11;
      2'd1: dark_steps = 4'd10;
      2'd2: dark_steps = 4'd2;
      default: dark_steps = 4'd1;
    endcase
  end

  always @(negedge clk) begin
    // R1
    if (!rst_n) reset_quiet_chk: assert (shared_on == 18'd0 && seg_on == 8'd0);
  end

  // R9
  dark_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (seg_on == 8'd0 && shared_on[17:8] == 10'd0));

  // R3
  lead_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q < dark_steps) |-> (seg_on == 8'd0 && shared_on[17:8] == 10'd0));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q != $past(sub_q)) |-> (sub_q == $past(sub_q) + 4'd1));

  // R4
  grid_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grid_q <= 4'd9);

  // R7
  addr_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr >= ADDR_W'(9) && mem_addr <= ADDR_W'(47) && mem_addr[1:0] != 2'd0));

  // R10
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q == $past(sub_q) && $stable(disp_on) && $stable(duty)) |-> $stable(seg_on));
endmodule

bind vfd_scan vfd_scan_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .duty(duty),
  .shared_on(shared_on), .seg_on(seg_on), .mem_addr(mem_addr),
  .sub_q(sub_q), .grid_q(grid_q)
);

// File: tb/vfd_scan_test.sv
module vfd_scan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  prescale = '0;
  logic [3:0]  grid_cnt = 4'd7, grid_start = '0;
  logic [4:0]  seg_cnt = 5'd8;
  logic [1:0]  duty = '0;
  logic        disp_on = 1'b0;
  logic [7:0]  port_val = '0;
  logic [5:0]  mem_addr;
  logic [7:0]  mem_rdata;
  logic [17:0] shared_on;
  logic [7:0]  seg_on;
  logic [7:0]  mem [0:63];

  int compared = 0, mismatched = 0;
  int cfg_n, cfg_st, cfg_sc, cfg_du, cfg_on, cfg_pv;

  always #2 clk = ~clk;
  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  vfd_scan uut (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .grid_cnt(grid_cnt),
    .grid_start(grid_start), .seg_cnt(seg_cnt), .duty(duty), .disp_on(disp_on),
    .port_val(port_val), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .shared_on(shared_on), .seg_on(seg_on)
  );

  function automatic logic [17:0] memword(input int g);
    int b = 9 + 4 * g;
    return {mem[b][1:0], mem[b + 1], mem[b + 2]};
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // R3 R5 R6 R8 R9: expected line pattern for grid g at sub-step s
  function automatic void expect_out(input int g, input int s, input logic [17:0] d,
                                     output logic [17:0] sh, output logic [7:0] sg);
    int nc = clampi(cfg_n, 7, 10);
    int top = 17 - clampi(cfg_st, 0, 10);
    int bottom = top - nc + 1;
    int segs = clampi(cfg_sc, 8, 18);
    int w = (cfg_du == 0) ? 5 : (cfg_du == 1) ? 6 : (cfg_du == 2) ? 14 : 15;
    bit on = (cfg_on != 0) && (s >= 16 - w);
    sh = '0;
    for (int k = 0; k < 18; k++) begin
      if (k >= bottom && k <= top)  sh[k] = on && (k == bottom + g);
      else if (k < 8)               sh[k] = cfg_pv[k];
      else if (25 - k < segs)       sh[k] = on && d[25 - k];
    end
    sg = on ? d[7:0] : 8'd0;
  endfunction

  task automatic run_cfg(input int n, input int st, input int sc, input int du, input int on,
                         input int p, input int pv, input int salt, input int wr_slot,
                         input string tag);
    int nc = clampi(n, 7, 10);
    int per = 16 * (p + 1);
    int total = (nc + 2) * per;
    int prev_slot = -1;
    logic [17:0] d = '0, esh;
    logic [7:0] esg;
    cfg_n = n; cfg_st = st; cfg_sc = sc; cfg_du = du; cfg_on = on; cfg_pv = pv;
    for (int a = 0; a < 64; a++) mem[a] = 8'((a * 29 + salt * 53 + 7) ^ (salt * 3));
    @(negedge clk);
    rst_n = 1'b0;
    grid_cnt = 4'(n); grid_start = 4'(st); seg_cnt = 5'(sc); duty = 2'(du);
    disp_on = 1'(on); prescale = 8'(p); port_val = 8'(pv);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      compared++;
      if (shared_on !== 18'd0 || seg_on !== 8'd0) begin
        mismatched++;
        $display("FAIL R1 reset: shared=%h seg=%h expected 0/0", shared_on, seg_on);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 1; c <= total; c++) begin
      int slot, sub, g;
      @(posedge clk); #1;
      slot = c / per;
      sub = (c / (p + 1)) % 16;
      g = slot % nc;
      if (slot != prev_slot) begin
        d = (slot == 0) ? 18'd0 : memword(g);
        prev_slot = slot;
      end
      expect_out(g, sub, d, esh, esg);
      compared++;
      if (shared_on !== esh || seg_on !== esg) begin
        mismatched++;
        $display("FAIL %s c=%0d grid=%0d sub=%0d shared=%h exp %h seg=%h exp %h",
                 tag, c, g, sub, shared_on, esh, seg_on, esg);
      end
      if (slot == wr_slot && (c % per) == 8) begin
        for (int b = 0; b < 3; b++) begin
          mem[9 + 4 * g + b] = ~mem[9 + 4 * g + b];
          mem[9 + 4 * ((g + 1) % nc) + b] = ~mem[9 + 4 * ((g + 1) % nc) + b];
        end
      end
    end
  endtask

  bit done = 1'b0;

  initial begin
    #800000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int salt = 1;
    for (int a = 0; a < 64; a++) mem[a] = '0;
    // R2 R3 R4 R5 R6 R7 R8 R10 sweep over grid count, start code and duty
    for (int n = 7; n <= 10; n++)
      for (int st = 0; st <= 10; st++)
        for (int du = 0; du < 4; du++) begin
          run_cfg(n, st, 8 + ((n * 3 + st * 5 + du) % 11), du, 1, du % 2,
                  (salt * 73) & 255, salt, -1, "R2 R3 R4 R5 R6 R7 R8");
          salt++;
        end
    // R9 display off, ports still live
    run_cfg(8, 3, 18, 3, 0, 0, 8'hA5, 91, -1, "R9 R8");
    // R4 R5 R6 clamping of out-of-range settings
    run_cfg(3, 14, 2, 1, 1, 0, 8'h3C, 92, -1, "R4 R5 R6 clamp low");
    run_cfg(15, 0, 25, 2, 1, 1, 8'hC3, 93, -1, "R4 R5 R6 clamp high");
    // R2 longer sub-step
    run_cfg(9, 5, 12, 2, 1, 3, 8'h5A, 94, -1, "R2 prescale");
    // R10 mid-slot memory writes stay hidden until the next slot
    run_cfg(7, 0, 18, 3, 1, 1, 8'hFF, 95, 3, "R10 no tearing");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule